// File: doc/BRIEF.md
# Write-Coalescing Miss Queue

This block sits beside a data cache that does not fetch a line when a store misses. A missing store is written into a small queue entry that holds one whole line with a valid flag per byte; it counts as done as soon as the queue takes it. Later stores to the same line merge into that entry. When every byte of a line has been written, the entry goes to lower memory as a full-line write and never enters the cache.

Entries that stay partial are turned into ordinary fills when something asks for it: a load that misses or only partly overlaps a queued line, a fence that is being held, or a queue with every entry in use. A free-running LFSR picks the partial entry. The line is read from lower memory, the stored bytes are laid over the returned bytes, and the merged line goes out on the fill port. A load whose enabled bytes are all valid in a queued line is answered from the queue. The control is one state machine. Its states are IDLE, WRITEBACK (a full-line write is offered), FETCH (a line read is offered) and AWAIT (the read data is awaited). The transitions are IDLE to WRITEBACK when a full entry exists, IDLE to FETCH when there is demand and a partial entry, WRITEBACK to IDLE on request accept, FETCH to AWAIT on request accept, and AWAIT to IDLE on response.

Top module: `mq_write_coalesce`

## Requirements
- R1: After reset no entry is valid, `st_ready` is 1, `mem_req_valid` and `fill_valid` are 0, and a held fence is acknowledged at once.
- R2: `st_ready` is 1 when a valid entry holds `st_line` and that entry is not in use by the state machine, or when no entry holds the line and a free entry exists. Otherwise it is 0. A store never causes a lower-level request by itself.
- R3: Stores to one line merge into one entry. Byte `st_word*8+i` of the line takes `st_data[8i+7:8i]` when `st_be[i]` is 1. A later store overwrites earlier bytes.
- R4: A fully written entry is offered as `mem_req_valid` with `mem_req_write`=1, its line and all 32 bytes (byte k at bits 8k+7:8k). It is freed when `mem_req_ready` is 1 and it produces no fill.
- R5: A read request (`mem_req_write`=0) is only issued in the cycle after one with demand and with no full entry. Demand is a load that waits or misses since the last read decision, a held `fence_valid`, or all entries valid. The requested line is a queued partial line.
- R6: On `mem_rsp_valid` in the AWAIT state, `fill_valid` is 1 for that cycle with the fetched line. Each byte comes from the queue when it is valid there and from `mem_rsp_data` otherwise. The entry is freed.
- R7: A load whose enabled bytes are all valid in a queued line gives `ld_hit`=1 and those bytes on `ld_data`. Other bytes read as 0.
- R8: A load that overlaps some but not all of its enabled bytes with valid bytes of a queued line gives `ld_wait`. Any other load gives `ld_miss`. Exactly one of `ld_hit`, `ld_wait`, `ld_miss` is 1 while `ld_valid` is 1.
- R9: `fence_ack` is 1 only while `fence_valid` is 1, no entry is valid and the machine is in IDLE.
- R10: While an entry is offered or being fetched, a store to its line gets `st_ready`=0. A request held with `mem_req_ready`=0 keeps its line and kind.
- R11: A load and a store to the same word in one cycle: the load sees the contents from before the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| st_valid | input | 1 | Store miss presented |
| st_line | input | 27 | Store line address |
| st_word | input | 2 | Word within the line |
| st_be | input | 8 | Store byte enables |
| st_data | input | 64 | Store data |
| st_ready | output | 1 | Store accepted this cycle |
| ld_valid | input | 1 | Load presented |
| ld_line | input | 27 | Load line address |
| ld_word | input | 2 | Word within the line |
| ld_be | input | 8 | Load byte enables |
| ld_hit | output | 1 | Load served from the queue |
| ld_wait | output | 1 | Load partly covered, must retry |
| ld_miss | output | 1 | Load not covered by the queue |
| ld_data | output | 64 | Load data on hit |
| fence_valid | input | 1 | Fence held until acknowledged |
| fence_ack | output | 1 | Queue drained |
| mem_req_valid | output | 1 | Lower-memory request |
| mem_req_write | output | 1 | 1 full-line write, 0 line read |
| mem_req_line | output | 27 | Request line address |
| mem_req_data | output | 256 | Full-line write data |
| mem_req_ready | input | 1 | Request accepted |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 256 | Returned line |
| fill_valid | output | 1 | Merged line for the cache |
| fill_line | output | 27 | Fill line address |
| fill_data | output | 256 | Merged fill data |

## Verification
Two functions can meet in one cycle: a load can be answered from an entry while a store merges into the same word, and a store to a line can arrive while that line's fill or write-back is in flight. The bench drives a store and a load to one word in the same cycle and requires the load to return the older bytes. While a read response is held back, it sends stores to the line named on the request port and requires them to be refused. A behavioural model of lines and byte masks judges every cycle, and a long mixed stream repeats both collisions at random.

// File: rtl/mq_pkg.sv
package mq_pkg;
    typedef enum logic [1:0] {
        MQ_IDLE      = 2'd0,
        MQ_WRITEBACK = 2'd1,
        MQ_FETCH     = 2'd2,
        MQ_AWAIT     = 2'd3
    } mq_state_e;
endpackage

// File: rtl/mq_lookup.sv
// Associative match of a line address against all queue entries.
module mq_lookup #(
    parameter int N  = 4,
    parameter int AW = 27,
    parameter int IW = 2
) (
    input  logic [N-1:0]    vld,
    input  logic [N*AW-1:0] lines,
    input  logic [AW-1:0]   key,
    output logic            hit,
    output logic [IW-1:0]   idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!hit && vld[i] && lines[i*AW +: AW] == key) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mq_victim_pick.sv
// Free-running LFSR chooses a rotating start point; the first eligible
// entry at or after it is selected.
module mq_victim_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  elig,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [7:0] lfsr;
    int         start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr <= 8'hA5;
        else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    always_comb begin
        start = int'(lfsr) % N;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            if (!found && elig[(start + k) % N]) begin
                found = 1'b1;
                idx   = IW'((start + k) % N);
            end
        end
    end
endmodule

// File: rtl/mq_write_coalesce.sv
module mq_write_coalesce
    import mq_pkg::*;
#(
    parameter int ENTRIES    = 4,
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 8,
    parameter int LINE_AW    = 27,
    localparam int IW = $clog2(ENTRIES),
    localparam int WI = $clog2(LINE_BYTES / WORD_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_valid,
    input  logic [LINE_AW-1:0]      st_line,
    input  logic [WI-1:0]           st_word,
    input  logic [WORD_BYTES-1:0]   st_be,
    input  logic [WORD_BYTES*8-1:0] st_data,
    output logic                    st_ready,
    input  logic                    ld_valid,
    input  logic [LINE_AW-1:0]      ld_line,
    input  logic [WI-1:0]           ld_word,
    input  logic [WORD_BYTES-1:0]   ld_be,
    output logic                    ld_hit,
    output logic                    ld_wait,
    output logic                    ld_miss,
    output logic [WORD_BYTES*8-1:0] ld_data,
    input  logic                    fence_valid,
    output logic                    fence_ack,
    output logic                    mem_req_valid,
    output logic                    mem_req_write,
    output logic [LINE_AW-1:0]      mem_req_line,
    output logic [LINE_BYTES*8-1:0] mem_req_data,
    input  logic                    mem_req_ready,
    input  logic                    mem_rsp_valid,
    input  logic [LINE_BYTES*8-1:0] mem_rsp_data,
    output logic                    fill_valid,
    output logic [LINE_AW-1:0]      fill_line,
    output logic [LINE_BYTES*8-1:0] fill_data
);
    localparam int LB = LINE_BYTES;
    localparam int WB = WORD_BYTES;

    mq_state_e state, state_nxt;

    logic [LINE_AW-1:0] e_line [ENTRIES];
    logic [LB-1:0]      e_mask [ENTRIES];
    logic [LB*8-1:0]    e_data [ENTRIES];
    logic [ENTRIES-1:0] e_vld;
    logic [ENTRIES*LINE_AW-1:0] lines_flat;
    logic [ENTRIES-1:0] full_vec, part_vec;

    logic [IW-1:0] b_idx, b_idx_nxt;
    logic          rd_dem;

    // per-entry summaries
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign lines_flat[g*LINE_AW +: LINE_AW] = e_line[g];
        assign full_vec[g] = e_vld[g] &&  (&e_mask[g]);
        assign part_vec[g] = e_vld[g] && !(&e_mask[g]);
    end

    logic s_hit, l_hit, pick_found;
    logic [IW-1:0] s_idx, l_idx, pick_idx;

    mq_lookup #(.N(ENTRIES), .AW(LINE_AW), .IW(IW)) u_st_lookup (
        .vld(e_vld), .lines(lines_flat), .key(st_line), .hit(s_hit), .idx(s_idx));
    mq_lookup #(.N(ENTRIES), .AW(LINE_AW), .IW(IW)) u_ld_lookup (
        .vld(e_vld), .lines(lines_flat), .key(ld_line), .hit(l_hit), .idx(l_idx));
    mq_victim_pick #(.N(ENTRIES), .IW(IW)) u_pick (
        .clk(clk), .rst_n(rst_n), .elig(part_vec), .found(pick_found), .idx(pick_idx));

    // free slot and first full entry
    logic          free_found, full_found;
    logic [IW-1:0] free_idx, full_idx;
    always_comb begin
        free_found = 1'b0; free_idx = '0;
        full_found = 1'b0; full_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!free_found && !e_vld[i]) begin free_found = 1'b1; free_idx = IW'(i); end
            if (!full_found && full_vec[i]) begin full_found = 1'b1; full_idx = IW'(i); end
        end
    end

    // store acceptance
    logic          busy, st_fire;
    logic [IW-1:0] tgt;
    logic [LB-1:0] st_bmask;
    int            st_base;
    assign busy     = (state != MQ_IDLE);
    assign st_ready = s_hit ? !(busy && s_idx == b_idx) : free_found;
    assign st_fire  = st_valid && st_ready;
    assign tgt      = s_hit ? s_idx : free_idx;
    assign st_base  = int'(st_word) * WB;
    assign st_bmask = {{(LB-WB){1'b0}}, st_be} << st_base;

    // load lookup
    logic [WB-1:0]   l_mw;
    logic [WB*8-1:0] l_raw;
    logic            l_cov, l_ovl, load_dem;
    assign l_mw  = e_mask[l_idx][int'(ld_word)*WB +: WB];
    assign l_raw = e_data[l_idx][int'(ld_word)*WB*8 +: WB*8];
    assign l_cov = (ld_be & ~l_mw) == '0;
    assign l_ovl = |(ld_be & l_mw);
    assign ld_hit  = ld_valid && l_hit && l_cov;
    assign ld_wait = ld_valid && l_hit && !l_cov && l_ovl;
    assign ld_miss = ld_valid && !ld_hit && !ld_wait;
    assign load_dem = ld_wait || ld_miss;

    always_comb begin
        for (int b = 0; b < WB; b++)
            ld_data[b*8 +: 8] = ld_be[b] ? l_raw[b*8 +: 8] : 8'h00;
    end

    // next state
    logic demand, start_fetch, free_evt;
    assign demand = rd_dem || fence_valid || (&e_vld);

    always_comb begin
        state_nxt   = state;
        b_idx_nxt   = b_idx;
        start_fetch = 1'b0;
        unique case (state)
            MQ_IDLE: begin
                if (full_found) begin
                    state_nxt = MQ_WRITEBACK;
                    b_idx_nxt = full_idx;
                end else if (demand && pick_found) begin
                    state_nxt   = MQ_FETCH;
                    b_idx_nxt   = pick_idx;
                    start_fetch = 1'b1;
                end
            end
            MQ_WRITEBACK: if (mem_req_ready) state_nxt = MQ_IDLE;
            MQ_FETCH:     if (mem_req_ready) state_nxt = MQ_AWAIT;
            MQ_AWAIT:     if (mem_rsp_valid) state_nxt = MQ_IDLE;
            default:      state_nxt = MQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= MQ_IDLE;
            b_idx  <= '0;
            rd_dem <= 1'b0;
        end else begin
            state  <= state_nxt;
            b_idx  <= b_idx_nxt;
            rd_dem <= (rd_dem && !start_fetch) || load_dem;
        end
    end

    // outputs
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        fill_valid    = 1'b0;
        unique case (state)
            MQ_WRITEBACK: begin mem_req_valid = 1'b1; mem_req_write = 1'b1; end
            MQ_FETCH:     mem_req_valid = 1'b1;
            MQ_AWAIT:     fill_valid = mem_rsp_valid;
            default:      ;
        endcase
        mem_req_line = e_line[b_idx];
        mem_req_data = e_data[b_idx];
        fill_line    = e_line[b_idx];
        for (int k = 0; k < LB; k++)
            fill_data[k*8 +: 8] = e_mask[b_idx][k] ? e_data[b_idx][k*8 +: 8]
                                                   : mem_rsp_data[k*8 +: 8];
        fence_ack = fence_valid && !busy && !(|e_vld);
    end

    assign free_evt = (state == MQ_WRITEBACK && mem_req_ready) ||
                      (state == MQ_AWAIT && mem_rsp_valid);

    // entry valid flags and byte masks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_vld <= '0;
            for (int i = 0; i < ENTRIES; i++) e_mask[i] <= '0;
        end else begin
            if (free_evt) e_vld[b_idx] <= 1'b0;
            if (st_fire) begin
                e_vld[tgt]  <= 1'b1;
                e_mask[tgt] <= (s_hit ? e_mask[tgt] : '0) | st_bmask;
            end
        end
    end

    // entry line addresses and data
    always_ff @(posedge clk) begin
        if (st_fire) begin
            if (!s_hit) e_line[tgt] <= st_line;
            for (int b = 0; b < WB; b++)
                if (st_be[b]) e_data[tgt][(st_base + b)*8 +: 8] <= st_data[b*8 +: 8];
        end
    end
endmodule

// File: rtl/mq_write_coalesce_chk.sv
module mq_write_coalesce_chk #(
    parameter int LINE_AW = 27
) (
    input logic               clk,
    input logic               rst_n,
    input logic               st_valid,
    input logic [LINE_AW-1:0] st_line,
    input logic               st_ready,
    input logic               ld_valid,
    input logic               ld_hit,
    input logic               ld_wait,
    input logic               ld_miss,
    input logic               fence_ack,
    input logic               mem_req_valid,
    input logic               mem_req_write,
    input logic [LINE_AW-1:0] mem_req_line,
    input logic               mem_req_ready,
    input logic               mem_rsp_valid,
    input logic               fill_valid
);
    // R8
    load_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $countones({ld_hit, ld_wait, ld_miss}) == 1);

    // R8
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> !(ld_hit || ld_wait || ld_miss));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_line) && $stable(mem_req_write)));

    // R10
    busy_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && st_valid && st_line == mem_req_line) |-> !st_ready);

    // R6
    fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (mem_rsp_valid && !mem_req_valid));

    // R9
    fence_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_ack |-> !mem_req_valid && !fill_valid);
endmodule

bind mq_write_coalesce mq_write_coalesce_chk #(.LINE_AW(LINE_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_line(st_line),
    .st_ready(st_ready), .ld_valid(ld_valid), .ld_hit(ld_hit),
    .ld_wait(ld_wait), .ld_miss(ld_miss), .fence_ack(fence_ack),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_line(mem_req_line), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .fill_valid(fill_valid));

// File: tb/test_mq_write_coalesce.sv
module test_mq_write_coalesce;
    localparam int E  = 4;
    localparam int LA = 27;

    logic clk = 1'b0, rst_n = 1'b0;
    logic st_valid = 0, st_ready;
    logic [LA-1:0] st_line = '0;
    logic [1:0] st_word = '0;
    logic [7:0] st_be = '0;
    logic [63:0] st_data = '0;
    logic ld_valid = 0, ld_hit, ld_wait, ld_miss;
    logic [LA-1:0] ld_line = '0;
    logic [1:0] ld_word = '0;
    logic [7:0] ld_be = '0;
    logic [63:0] ld_data;
    logic fence_valid = 0, fence_ack;
    logic mem_req_valid, mem_req_write, mem_req_ready = 1;
    logic [LA-1:0] mem_req_line;
    logic [255:0] mem_req_data;
    logic mem_rsp_valid = 0;
    logic [255:0] mem_rsp_data = '0;
    logic fill_valid;
    logic [LA-1:0] fill_line;
    logic [255:0] fill_data;

    always #2 clk = ~clk;

    mq_write_coalesce i_mq_write_coalesce (.*);

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // behavioural model: queued lines keyed by address
    logic [255:0] m_data [int];
    logic [31:0]  m_mask [int];
    bit  busy = 0, rd_pend = 0;
    int  busy_line = 0, rsp_cnt = 0, rsp_delay = 2;
    bit  m_dem = 0, last_ld_dem = 0, p_dem = 0, p_full = 0;

    task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] rsp_pat(int ln);
        logic [255:0] r;
        for (int k = 0; k < 8; k++) r[k*32 +: 32] = ln * 32'h01000193 + k * 32'h1111;
        return r;
    endfunction

    function automatic bit any_full();
        foreach (m_mask[k]) if (&m_mask[k]) return 1;
        return 0;
    endfunction

    // one clock: inputs already set at the falling edge
    task automatic tick();
        bit exp_rdy, ldd, new_req, wr_done, rd_acc, rsp_now;
        int k;
        logic [7:0] mw;
        logic [63:0] ed;
        mem_rsp_valid = rd_pend && rsp_cnt == 0;
        mem_rsp_data  = rsp_pat(busy_line);
        #1;
        // R2 / R10: store acceptance
        k = int'(st_line);
        exp_rdy = m_mask.exists(k) ? !(busy && busy_line == k) : (m_mask.num() < E);
        new_req = mem_req_valid && !busy;
        if (new_req && int'(mem_req_line) == k) exp_rdy = 0;
        chk(st_ready == exp_rdy, "R2/R10 st_ready", 256'(st_ready), 256'(exp_rdy));
        // R7 / R8 / R11: loads see contents from before this edge
        ldd = 0;
        if (ld_valid) begin
            k = int'(ld_line);
            if (m_mask.exists(k)) begin
                mw = m_mask[k][ld_word*8 +: 8];
                for (int b = 0; b < 8; b++)
                    ed[b*8 +: 8] = ld_be[b] ? m_data[k][(ld_word*8 + b)*8 +: 8] : 8'h00;
                if ((ld_be & ~mw) == 0) begin
                    chk(ld_hit, "R7 hit", 256'(ld_hit), 1);
                    chk(ld_data == ed, "R7/R11 data", 256'(ld_data), 256'(ed));
                end else if ((ld_be & mw) != 0) begin
                    chk(ld_wait, "R8 wait", 256'(ld_wait), 1); ldd = 1;
                end else begin
                    chk(ld_miss, "R8 miss", 256'(ld_miss), 1); ldd = 1;
                end
            end else begin
                chk(ld_miss, "R8 miss", 256'(ld_miss), 1); ldd = 1;
            end
        end
        // R4 / R5: lower-memory requests
        if (new_req) begin
            busy = 1; busy_line = int'(mem_req_line);
            chk(m_mask.exists(busy_line), "R4/R5 line queued", 256'(mem_req_line), 0);
            if (m_mask.exists(busy_line)) begin
                if (mem_req_write) begin
                    chk(&m_mask[busy_line], "R4 full", 256'(m_mask[busy_line]), 256'(32'hFFFFFFFF));
                    chk(mem_req_data == m_data[busy_line], "R4 data", mem_req_data, m_data[busy_line]);
                end else begin
                    chk(p_dem, "R5 demand", 256'(p_dem), 1);
                    chk(!p_full, "R5 full first", 256'(p_full), 0);
                end
            end
        end else if (busy && mem_req_valid) begin
            chk(int'(mem_req_line) == busy_line, "R10 hold", 256'(mem_req_line), 256'(busy_line));
        end else if (!busy) begin
            chk(!mem_req_valid, "R2 no request", 256'(mem_req_valid), 0);
        end
        // R6: fill
        rsp_now = mem_rsp_valid;
        chk(fill_valid == rsp_now, "R6 fill_valid", 256'(fill_valid), 256'(rsp_now));
        if (rsp_now && fill_valid && m_mask.exists(busy_line)) begin
            for (int b = 0; b < 32; b++)
                ed = '0;
            begin
                logic [255:0] mg;
                for (int b = 0; b < 32; b++)
                    mg[b*8 +: 8] = m_mask[busy_line][b] ? m_data[busy_line][b*8 +: 8]
                                                         : mem_rsp_data[b*8 +: 8];
                chk(fill_data == mg, "R6 merge", fill_data, mg);
                chk(int'(fill_line) == busy_line, "R6 line", 256'(fill_line), 256'(busy_line));
            end
        end
        // R9: fence
        chk(fence_ack == (fence_valid && m_mask.num() == 0 && !busy), "R9 fence_ack",
            256'(fence_ack), 256'(fence_valid && m_mask.num() == 0 && !busy));
        wr_done = mem_req_valid && mem_req_write && mem_req_ready;
        rd_acc  = mem_req_valid && !mem_req_write && mem_req_ready;
        p_dem  = m_dem || fence_valid || (m_mask.num() == E);
        p_full = any_full();
        @(posedge clk);
        if (st_valid && exp_rdy) begin
            k = int'(st_line);
            if (!m_mask.exists(k)) begin m_mask[k] = '0; m_data[k] = '0; end
            for (int b = 0; b < 8; b++)
                if (st_be[b]) begin
                    m_mask[k][st_word*8 + b] = 1'b1;
                    m_data[k][(st_word*8 + b)*8 +: 8] = st_data[b*8 +: 8];
                end
        end
        if (wr_done || rsp_now) begin
            m_mask.delete(busy_line); m_data.delete(busy_line);
            busy = 0; rd_pend = 0;
        end
        if (rd_acc) begin rd_pend = 1; rsp_cnt = rsp_delay; end
        else if (rd_pend && rsp_cnt > 0) rsp_cnt--;
        if (new_req && !mem_req_write) m_dem = last_ld_dem;
        m_dem = m_dem || ldd;
        last_ld_dem = ldd;
        @(negedge clk);
    endtask

    task automatic idle_in();
        st_valid = 0; ld_valid = 0;
    endtask

    task automatic store(int ln, int w, logic [7:0] be, logic [63:0] d);
        st_valid = 1; st_line = LA'(ln); st_word = 2'(w); st_be = be; st_data = d;
    endtask

    task automatic load(int ln, int w, logic [7:0] be);
        ld_valid = 1; ld_line = LA'(ln); ld_word = 2'(w); ld_be = be;
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && (m_mask.num() != 0 || busy); i++) tick();
        chk(m_mask.num() == 0 && !busy, "R9 drained", 256'(m_mask.num()), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        // R1: reset state
        fence_valid = 1;
        #1;
        chk(st_ready && !mem_req_valid && !fill_valid && fence_ack, "R1 reset",
            {st_ready, mem_req_valid, fill_valid, fence_ack}, 4'b1001);
        @(negedge clk);
        fence_valid = 0;
        // R3/R7/R8: partial line, merges, loads
        store(10, 0, 8'h0F, 64'h1111_2222_3333_4444); tick();
        store(10, 0, 8'h30, 64'h0055_6600_0000_0000); tick();
        idle_in();
        load(10, 0, 8'h3F); tick();            // R7 hit
        load(10, 0, 8'hFF); tick();            // R8 wait
        load(10, 2, 8'h01); tick();            // R8 miss, no overlap
        idle_in(); tick(); tick(); tick(); tick(); tick(); tick();
        // R11: store and load to one word together
        store(11, 1, 8'hFF, 64'hAAAA_BBBB_CCCC_DDDD); tick();
        store(11, 1, 8'hFF, 64'h1234_5678_9ABC_DEF0);
        load(11, 1, 8'hFF); tick();
        idle_in(); load(11, 1, 8'hFF); tick();
        idle_in();
        drain();
        // R4: four full words, written back, with a held request
        mem_req_ready = 0;
        for (int w = 0; w < 4; w++) begin store(20, w, 8'hFF, 64'(w) * 64'h0101_0101_0101_0101 + 64'h77); tick(); end
        idle_in(); tick(); tick();
        store(20, 0, 8'h01, 64'h5); tick();    // R10 stalled during offer
        idle_in(); tick();
        mem_req_ready = 1; tick(); tick();
        // R5/R6: queue pressure with four partial lines, slow response
        rsp_delay = 5;
        for (int l = 0; l < 4; l++) begin store(30 + l, l, 8'h81, 64'hF0 + 64'(l)); tick(); end
        idle_in();
        for (int i = 0; i < 12; i++) begin
            if (busy) store(busy_line, 0, 8'hFF, 64'h9);   // R10 refusals
            else idle_in();
            tick();
        end
        idle_in();
        fence_valid = 1; drain(); tick();
        fence_valid = 0; tick();
        // mixed stream
        rsp_delay = 1;
        seed = 7;
        for (int i = 0; i < 3000; i++) begin
            int r;
            seed = seed * 1103515245 + 12345; r = (seed >>> 8) & 32'h7FFF_FFFF;
            idle_in();
            if (r % 3 != 0) store(40 + (r >> 4) % 6, (r >> 8) % 4, 8'((r >> 10) | 1), {r, ~r});
            if ((r >> 3) % 4 == 0) load(40 + (r >> 12) % 6, (r >> 16) % 4, 8'(r >> 18) | 8'h01);
            fence_valid = ((r >> 20) % 16 == 0);
            mem_req_ready = ((r >> 24) % 4 != 0);
            tick();
        end
        idle_in(); mem_req_ready = 1; fence_valid = 1;
        drain(); tick();
        fence_valid = 0;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule